// File: doc/BRIEF.md
# Clock Mode Transition Controller

This block is a synchronous state machine that records which of eight clock-generation modes is in force. From that mode it drives the controls of the multiplexer that produces the main clock. The multiplexer can take the internal reference, the external reference, the frequency-locked loop or the phase-locked loop. A separate enable bit runs each of the two loops.

Software asks for a mode by pulsing a request with a target code. The controller never jumps straight to the target. It walks a fixed tree of permitted single-step edges, one hop at a time, along the shortest path. Before each hop it waits for that hop's readiness inputs: the external oscillator is good, the FLL is locked, the PLL is locked. If a hop stays unready past a programmable number of cycles, or the request is not allowed, a sticky error flag is raised and the mode does not change.

A stop input parks both loops from any mode. When stop is released, the controller resumes the mode it held before.

Top module: `clkmode_walker`

## Requirements
- R1: After reset the mode is 0 (FLL engaged, internal reference), the select is 2, fll_en_o is 1, pll_en_o is 0, and err_o, busy_o and stopped_o are 0.
- R2: Each mode code sets the outputs as follows:
  - 0 and 1 (FLL engaged, internal or external reference): select 2 (FLL), FLL on.
  - 2 (FLL bypass, internal): select 0, FLL on.
  - 3 (FLL bypass, external): select 1, FLL on.
  - 4 (PLL bypass, external): select 1, PLL on.
  - 5 (PLL engaged, external): select 3, PLL on.
  - 6 (low power, internal): select 0, both loops off.
  - 7 (low power, external): select 1, both loops off.
  - The select encoding is 0 internal, 1 external, 2 FLL, 3 PLL.
- R3: The only edges, usable in both directions, are 0-1, 0-2, 0-3, 2-6, 3-4, 3-7 and 4-5. A walk changes the mode by one edge per hop and follows the shortest path to the target.
- R4: A request for mode 5 from reset passes through modes 3 and 4 before it reaches 5. It never goes from 0 to 5 in one step.
- R5: A hop happens only on a clock edge at which its readiness holds:
  - Into modes 1, 3, 4, 5 or 7, ext_ok must be high.
  - Into mode 5, pll_lock must also be high.
  - Into modes 0 or 1, fll_lock must be high.
- R6: Suppose a hop is still unready on the clock edge after it has waited tmo_limit+1 cycles. Then err_o is set, the walk ends with busy_o low, and the mode stays where it was.
- R7: From mode 6 the only allowed target is 2, and from mode 7 the only allowed target is 3. Any other request from those modes sets err_o and leaves the mode unchanged.
- R8: Once err_o is set it stays set until reset, even across later successful walks.
- R9: While stop_req is high, stopped_o is 1, both loop enables are 0, and the mode code and select are held. When stop_req is released, the mode's normal outputs return one cycle later.
- R10: All outputs are registered. With no change of mode and no entry to or exit from stop, the select and enables stay constant.
- R11: A request made while busy_o is high is ignored. A request for the current mode starts no walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle pulse that takes req_mode as the new target |
| req_mode | input | 3 | Target mode code |
| stop_req | input | 1 | Level input that holds the controller in stop |
| ext_ok | input | 1 | External reference is valid |
| fll_lock | input | 1 | FLL is locked |
| pll_lock | input | 1 | PLL is locked |
| tmo_limit | input | CW | Number of cycles a hop may wait for readiness |
| mode_o | output | 3 | Current mode code |
| src_sel_o | output | 2 | Clock multiplexer select |
| fll_en_o | output | 1 | FLL enable |
| pll_en_o | output | 1 | PLL enable |
| busy_o | output | 1 | A walk is in progress |
| stopped_o | output | 1 | Controller is in stop |
| err_o | output | 1 | Sticky error |

## Verification
The assertions assume two things about the inputs:
- tmo_limit does not change while a walk is in progress, since the wait counter is bounded by it.
- A request arrives as a single-cycle pulse sampled on the clock.

The bench holds tmo_limit fixed within each scenario and changes it only while the controller is idle. It drives every input one nanosecond after the rising edge, so each value is stable over a full cycle. Random walks keep all readiness inputs high and pick only allowed targets. The cases with delayed readiness, refused requests and stop are driven as directed sequences.

// File: rtl/ckm_pkg.sv
package ckm_pkg;

  localparam int MW = 3;

  localparam logic [MW-1:0] MD_FLL_INT = 3'd0;
  localparam logic [MW-1:0] MD_FLL_EXT = 3'd1;
  localparam logic [MW-1:0] MD_BYP_INT = 3'd2;
  localparam logic [MW-1:0] MD_BYP_EXT = 3'd3;
  localparam logic [MW-1:0] MD_PBY_EXT = 3'd4;
  localparam logic [MW-1:0] MD_PLL_EXT = 3'd5;
  localparam logic [MW-1:0] MD_LP_INT  = 3'd6;
  localparam logic [MW-1:0] MD_LP_EXT  = 3'd7;

  localparam logic [1:0] SRC_INT = 2'd0;
  localparam logic [1:0] SRC_EXT = 2'd1;
  localparam logic [1:0] SRC_FLL = 2'd2;
  localparam logic [1:0] SRC_PLL = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_STOP} fsm_e;

  typedef struct packed {
    logic [1:0] sel;
    logic       fll_en;
    logic       pll_en;
  } ctl_t;

  // The edge set is a tree rooted at the reset mode.
  function automatic logic [MW-1:0] mode_parent(logic [MW-1:0] m);
    case (m)
      MD_FLL_EXT, MD_BYP_INT, MD_BYP_EXT: return MD_FLL_INT;
      MD_PBY_EXT, MD_LP_EXT:              return MD_BYP_EXT;
      MD_LP_INT:                          return MD_BYP_INT;
      MD_PLL_EXT:                         return MD_PBY_EXT;
      default:                            return MD_FLL_INT;
    endcase
  endfunction

  function automatic logic [1:0] mode_depth(logic [MW-1:0] m);
    case (m)
      MD_FLL_INT:                         return 2'd0;
      MD_FLL_EXT, MD_BYP_INT, MD_BYP_EXT: return 2'd1;
      MD_PLL_EXT:                         return 2'd3;
      default:                            return 2'd2;
    endcase
  endfunction

  // Ancestor of m at depth d, or m itself if it is not deeper than d.
  function automatic logic [MW-1:0] mode_anc(logic [MW-1:0] m, logic [1:0] d);
    logic [MW-1:0] x;
    x = m;
    for (int i = 0; i < 3; i++)
      if (mode_depth(x) > d) x = mode_parent(x);
    return x;
  endfunction

  function automatic ctl_t mode_ctl(logic [MW-1:0] m);
    ctl_t c;
    case (m)
      MD_FLL_INT, MD_FLL_EXT: c = '{sel: SRC_FLL, fll_en: 1'b1, pll_en: 1'b0};
      MD_BYP_INT:             c = '{sel: SRC_INT, fll_en: 1'b1, pll_en: 1'b0};
      MD_BYP_EXT:             c = '{sel: SRC_EXT, fll_en: 1'b1, pll_en: 1'b0};
      MD_PBY_EXT:             c = '{sel: SRC_EXT, fll_en: 1'b0, pll_en: 1'b1};
      MD_PLL_EXT:             c = '{sel: SRC_PLL, fll_en: 1'b0, pll_en: 1'b1};
      MD_LP_INT:              c = '{sel: SRC_INT, fll_en: 1'b0, pll_en: 1'b0};
      default:                c = '{sel: SRC_EXT, fll_en: 1'b0, pll_en: 1'b0};
    endcase
    return c;
  endfunction

  function automatic logic mode_uses_ext(logic [MW-1:0] m);
    return (m == MD_FLL_EXT) || (m == MD_BYP_EXT) || (m == MD_PBY_EXT) ||
           (m == MD_PLL_EXT) || (m == MD_LP_EXT);
  endfunction

  function automatic logic mode_uses_fll_lock(logic [MW-1:0] m);
    return (m == MD_FLL_INT) || (m == MD_FLL_EXT);
  endfunction

endpackage

// File: rtl/ckm_router.sv
module ckm_router
  import ckm_pkg::*;
(
  input  logic [MW-1:0] cur,
  input  logic [MW-1:0] tgt,
  input  logic          ext_ok,
  input  logic          fll_lock,
  input  logic          pll_lock,
  output logic [MW-1:0] nxt,
  output logic          hop_ready,
  output logic          tgt_allowed
);

  logic [1:0]    dc;
  logic [1:0]    dt;
  logic          below;

  assign dc    = mode_depth(cur);
  assign dt    = mode_depth(tgt);
  assign below = (dt > dc) && (mode_anc(tgt, dc) == cur);

  always_comb begin
    if (tgt == cur)  nxt = cur;
    else if (below)  nxt = mode_anc(tgt, 2'(dc + 2'd1));
    else             nxt = mode_parent(cur);
  end

  always_comb begin
    hop_ready = 1'b1;
    if (mode_uses_ext(nxt) && !ext_ok)        hop_ready = 1'b0;
    if (nxt == MD_PLL_EXT && !pll_lock)       hop_ready = 1'b0;
    if (mode_uses_fll_lock(nxt) && !fll_lock) hop_ready = 1'b0;
  end

  // Low-power modes may only be left towards their own bypass mode.
  always_comb begin
    case (cur)
      MD_LP_INT: tgt_allowed = (tgt == MD_BYP_INT);
      MD_LP_EXT: tgt_allowed = (tgt == MD_BYP_EXT);
      default:   tgt_allowed = 1'b1;
    endcase
  end

endmodule

// File: rtl/ckm_wait.sv
module ckm_wait #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run)          cnt_q <= '0;
    else if (cnt_q != limit) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == limit);

  // R6: while waiting, the count never passes the programmed limit
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));

endmodule

// File: rtl/clkmode_walker.sv
module clkmode_walker
  import ckm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_mode,
  input  logic          stop_req,
  input  logic          ext_ok,
  input  logic          fll_lock,
  input  logic          pll_lock,
  input  logic [CW-1:0] tmo_limit,
  output logic [2:0]    mode_o,
  output logic [1:0]    src_sel_o,
  output logic          fll_en_o,
  output logic          pll_en_o,
  output logic          busy_o,
  output logic          stopped_o,
  output logic          err_o
);

  fsm_e          st_q;
  logic [MW-1:0] mode_q;
  logic [MW-1:0] tgt_q;
  ctl_t          ctl_q;
  logic          err_q;

  logic [MW-1:0] route_tgt;
  logic [MW-1:0] nxt;
  logic          hop_ready;
  logic          tgt_allowed;
  logic          expired;

  // Named events
  logic          ev_stop_in;
  logic          ev_wake;
  logic          ev_accept;
  logic          ev_refuse;
  logic          ev_hop;
  logic          ev_timeout;
  logic          wait_run;

  assign route_tgt = (st_q == ST_WALK) ? tgt_q : req_mode;

  ckm_router u_router (
    .cur        (mode_q),
    .tgt        (route_tgt),
    .ext_ok     (ext_ok),
    .fll_lock   (fll_lock),
    .pll_lock   (pll_lock),
    .nxt        (nxt),
    .hop_ready  (hop_ready),
    .tgt_allowed(tgt_allowed)
  );

  assign ev_stop_in = (st_q != ST_STOP) && stop_req;
  assign ev_wake    = (st_q == ST_STOP) && !stop_req;
  assign ev_accept  = (st_q == ST_IDLE) && !stop_req && req_valid &&
                      (req_mode != mode_q) && tgt_allowed;
  assign ev_refuse  = (st_q == ST_IDLE) && !stop_req && req_valid &&
                      (req_mode != mode_q) && !tgt_allowed;
  assign ev_hop     = (st_q == ST_WALK) && !stop_req && hop_ready;
  assign wait_run   = (st_q == ST_WALK) && !stop_req && !hop_ready;
  assign ev_timeout = expired;

  ckm_wait #(.CW(CW)) u_wait (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (wait_run),
    .limit  (tmo_limit),
    .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= MD_FLL_INT;
      tgt_q  <= MD_FLL_INT;
      ctl_q  <= mode_ctl(MD_FLL_INT);
      err_q  <= 1'b0;
    end else if (ev_stop_in) begin
      st_q         <= ST_STOP;
      ctl_q.fll_en <= 1'b0;
      ctl_q.pll_en <= 1'b0;
    end else if (ev_wake) begin
      st_q  <= ST_IDLE;
      ctl_q <= mode_ctl(mode_q);
    end else begin
      if (ev_accept) begin
        tgt_q <= req_mode;
        st_q  <= ST_WALK;
      end
      if (ev_refuse) err_q <= 1'b1;
      if (ev_hop) begin
        mode_q <= nxt;
        ctl_q  <= mode_ctl(nxt);
        if (nxt == tgt_q) st_q <= ST_IDLE;
      end else if (ev_timeout) begin
        err_q <= 1'b1;
        st_q  <= ST_IDLE;
      end
    end
  end

  assign mode_o    = mode_q;
  assign src_sel_o = ctl_q.sel;
  assign fll_en_o  = ctl_q.fll_en;
  assign pll_en_o  = ctl_q.pll_en;
  assign busy_o    = (st_q == ST_WALK);
  assign stopped_o = (st_q == ST_STOP);
  assign err_o     = err_q;

  // R3: every change of mode follows one tree edge
  a_r3_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |->
      (mode_parent(mode_q) == $past(mode_q) || mode_parent($past(mode_q)) == mode_q));

  // R5: the PLL-driven mode is only entered with lock present
  a_r5_pll_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_PLL_EXT && $past(mode_q) != MD_PLL_EXT) |-> $past(pll_lock));

  // R5: externally referenced modes are only entered with a valid reference
  a_r5_ext_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q) && mode_uses_ext(mode_q)) |-> $past(ext_ok));

  // R6: raising the error never moves the mode
  a_r6_hold_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $stable(mode_q));

  // R8: the error flag is sticky
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_q) |-> err_q);

  // R9: both loops are off while stopped, and the mode is held
  a_r9_loops_off: assert property (@(posedge clk) disable iff (!rst_n)
    stopped_o |-> (!fll_en_o && !pll_en_o));
  a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped_o && $past(stopped_o)) |-> $stable(mode_q));

  // R10: controls only move with a state update
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(mode_q) && $stable(st_q)) |-> $stable(ctl_q));

  // R2: PLL as source implies the PLL runs, unless stopped
  a_r2_pll_src: assert property (@(posedge clk) disable iff (!rst_n)
    (!stopped_o && src_sel_o == SRC_PLL) |-> pll_en_o);

endmodule

// File: tb/sim_clkmode_walker.sv
module sim_clkmode_walker;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_mode = 3'd0;
  logic          stop_req = 1'b0;
  logic          ext_ok = 1'b0;
  logic          fll_lock = 1'b0;
  logic          pll_lock = 1'b0;
  logic [CW-1:0] tmo_limit = 16'd20;
  logic [2:0]    mode_o;
  logic [1:0]    src_sel_o;
  logic          fll_en_o, pll_en_o, busy_o, stopped_o, err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  clkmode_walker #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .stop_req(stop_req), .ext_ok(ext_ok), .fll_lock(fll_lock), .pll_lock(pll_lock),
    .tmo_limit(tmo_limit), .mode_o(mode_o), .src_sel_o(src_sel_o),
    .fll_en_o(fll_en_o), .pll_en_o(pll_en_o), .busy_o(busy_o),
    .stopped_o(stopped_o), .err_o(err_o)
  );

  // Tree of permitted edges, written as an upward map
  function automatic logic [2:0] b_up(logic [2:0] m);
    case (m)
      3'd1, 3'd2, 3'd3: return 3'd0;
      3'd4, 3'd7:       return 3'd3;
      3'd6:             return 3'd2;
      3'd5:             return 3'd4;
      default:          return 3'd0;
    endcase
  endfunction

  function automatic bit b_under(logic [2:0] a, logic [2:0] m);
    logic [2:0] x = m;
    for (int k = 0; k < 4; k++) begin
      if (x == a) return 1'b1;
      if (x == 3'd0) return 1'b0;
      x = b_up(x);
    end
    return 1'b0;
  endfunction

  function automatic logic [2:0] b_next(logic [2:0] c, logic [2:0] t);
    if (c == t) return c;
    for (int cand = 0; cand < 8; cand++)
      if (cand[2:0] != c && b_up(cand[2:0]) == c && b_under(cand[2:0], t))
        return cand[2:0];
    return b_up(c);
  endfunction

  function automatic int b_len(logic [2:0] c, logic [2:0] t);
    int n = 0;
    logic [2:0] x = c;
    while (x != t && n < 8) begin
      x = b_next(x, t);
      n++;
    end
    return n;
  endfunction

  function automatic int b_sel(logic [2:0] m);
    case (m)
      3'd0, 3'd1: return 2;
      3'd2, 3'd6: return 0;
      3'd5:       return 3;
      default:    return 1;
    endcase
  endfunction

  function automatic int b_fll(logic [2:0] m);
    return (m <= 3'd3) ? 1 : 0;
  endfunction

  function automatic int b_pll(logic [2:0] m);
    return (m == 3'd4 || m == 3'd5) ? 1 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; req_valid = 1'b0; stop_req = 1'b0;
    tick; tick;
    rst_n = 1'b1;
  endtask

  task automatic request(input logic [2:0] m);
    req_valid = 1'b1; req_mode = m;
    tick;
    req_valid = 1'b0;
  endtask

  task automatic outs(input string tag, input logic [2:0] m);
    chk({tag, " mode"}, int'(mode_o), int'(m));
    chk({tag, " sel"},  int'(src_sel_o), b_sel(m));
    chk({tag, " fll"},  int'(fll_en_o),  b_fll(m));
    chk({tag, " pll"},  int'(pll_en_o),  b_pll(m));
  endtask

  task automatic walk_to(input logic [2:0] t);
    request(t);
    for (int k = 0; k < 10 && busy_o; k++) tick;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [2:0] cur, t, prev;
    int hops;
    void'($urandom(32'd4711));

    // R1 reset state
    fll_lock = 1'b1;
    do_reset;
    tick;
    outs("R1 reset", 3'd0);
    chk("R1 err", int'(err_o), 0);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 stopped", int'(stopped_o), 0);

    // R4/R5 directed route to the PLL mode with late readiness
    ext_ok = 1'b0; pll_lock = 1'b0; tmo_limit = 16'd20;
    request(3'd5);
    chk("R11 busy after request", int'(busy_o), 1);
    tick; tick; tick;
    chk("R5 waits for ext_ok", int'(mode_o), 0);
    ext_ok = 1'b1;
    tick;
    outs("R4 hop1", 3'd3);
    tick;
    outs("R4 hop2", 3'd4);
    tick; tick; tick;
    chk("R5 waits for pll_lock", int'(mode_o), 4);
    request(3'd6); // R11 ignored while busy
    pll_lock = 1'b1;
    tick;
    outs("R4 hop3", 3'd5);
    chk("R4 walk done", int'(busy_o), 0);
    chk("R6 no error", int'(err_o), 0);
    tick; tick;
    chk("R11 late request ignored", int'(mode_o), 5);

    // R11 request for the current mode
    request(3'd5);
    chk("R11 same mode no walk", int'(busy_o), 0);

    // R9 stop and wake
    stop_req = 1'b1;
    tick;
    chk("R9 stopped", int'(stopped_o), 1);
    chk("R9 fll off", int'(fll_en_o), 0);
    chk("R9 pll off", int'(pll_en_o), 0);
    chk("R9 sel held", int'(src_sel_o), 3);
    tick; tick;
    chk("R9 mode held", int'(mode_o), 5);
    stop_req = 1'b0;
    tick;
    chk("R9 awake", int'(stopped_o), 0);
    outs("R9 restore", 3'd5);

    // R6 timeout then R8 sticky
    do_reset;
    ext_ok = 1'b0; tmo_limit = 16'd5;
    request(3'd3);
    repeat (10) tick;
    chk("R6 err set", int'(err_o), 1);
    chk("R6 mode kept", int'(mode_o), 0);
    chk("R6 walk ended", int'(busy_o), 0);
    ext_ok = 1'b1;
    walk_to(3'd1);
    chk("R8 walk after error", int'(mode_o), 1);
    chk("R8 err sticky", int'(err_o), 1);

    // R6 readiness arriving just inside the window gives no error
    do_reset;
    ext_ok = 1'b0; tmo_limit = 16'd5;
    request(3'd3);
    repeat (4) tick;
    ext_ok = 1'b1;
    tick;
    chk("R6 late but in time", int'(mode_o), 3);
    chk("R6 no error in window", int'(err_o), 0);

    // R7 low-power exit rule
    do_reset;
    ext_ok = 1'b1; pll_lock = 1'b1; tmo_limit = 16'd20;
    walk_to(3'd6);
    outs("R7 in lp int", 3'd6);
    request(3'd0);
    tick;
    chk("R7 refused err", int'(err_o), 1);
    chk("R7 mode kept", int'(mode_o), 6);
    walk_to(3'd2);
    outs("R7 allowed exit", 3'd2);

    // R3/R2/R10 random walks with all readiness high
    do_reset;
    ext_ok = 1'b1; pll_lock = 1'b1; fll_lock = 1'b1;
    for (int it = 0; it < 80; it++) begin
      cur = mode_o;
      t = 3'($urandom_range(0, 7));
      if (cur == 3'd6) t = 3'd2;
      if (cur == 3'd7) t = 3'd3;
      request(t);
      hops = 0;
      prev = cur;
      if (mode_o != prev) begin
        hops++;
        prev = mode_o;
      end
      for (int k = 0; k < 10 && busy_o; k++) begin
        tick;
        if (mode_o != prev) begin
          chk("R3 single edge", int'(b_up(mode_o) == prev || b_up(prev) == mode_o), 1);
          hops++;
          prev = mode_o;
        end
      end
      chk("R3 reached target", int'(mode_o), int'(t));
      chk("R3 shortest path", hops, b_len(cur, t));
      outs("R2 decode", t);
      if ($urandom_range(0, 3) == 0) begin
        stop_req = 1'b1;
        tick; tick;
        chk("R9 random stop", int'(fll_en_o | pll_en_o), 0);
        stop_req = 1'b0;
        tick;
        outs("R9 random wake", t);
      end
      tick; tick;
      outs("R10 quiet", t);
    end
    chk("R8 no spurious error", int'(err_o), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule